// File: doc/BRIEF.md
# Multi-lane integer register file with lane enables

This block holds several copies ("lanes") of a 32-entry integer register file. Each lane has its own adder. One scalar register-register add is broadcast to every lane that is switched on. Each lane reads its own copies of the two source registers, using the same register numbers in every lane, and writes its own copy of the destination register. The adder either does a plain full-width add or a packed add. In a packed add, a shared partition mask cuts the carry chain at chosen bit positions, so several narrow elements are summed side by side.

A lane-enable register chooses which lanes take part. Writing a value that has no implemented lane bit set is a reset of the extra lanes. Lanes 1 and up are zeroed in a single cycle, their save-needed flags drop, and the enable register falls back to lane 0 alone.

A load port writes one register of one named lane, standing in for memory write-back. A per-lane save-needed flag records that a lane beyond lane 0 holds state. A registered debug port reads any register of any lane.

Top module: `lane_regfile`

## Requirements
- R1: After synchronous reset, `en_q` is 1, `dirty_q` is 0 and every register of every lane reads 0.
- R2: An enable write keeps only bits 0..NLANES-1 of `en_wdata`; all higher bits of `en_q` read 0.
- R3: An enable write whose value is 0 after masking (R2) does three things by the next cycle: it sets `en_q` to 1, zeroes every register in lanes 1..NLANES-1, and clears `dirty_q`. Lane 0 registers are kept.
- R4: With `op_valid`, every lane whose enable bit is 1 writes rs1+rs2 of its own data into rd. Lanes whose enable bit is 0 are unchanged.
- R5: With `op_packed`=1, each set bit i of `part_mask` blocks the carry into bit i, in every lane alike. Bit 0 has no effect. With `op_packed`=0 the mask is ignored.
- R6: Register 0 reads 0 in every lane. Adds and loads to register 0 change nothing and set no save-needed flag.
- R7: `dirty_q[i]` (i≥1) becomes 1 the cycle after any register of lane i is written by an add or a load. `dirty_q[0]` is always 0.
- R8: `dirty_clr` clears `dirty_q`. A write in the same cycle sets its flag anyway.
- R9: When an enable write and an add arrive in the same cycle, the add uses the newly written enable value (after R2/R3).
- R10: `dbg_data` shows register `dbg_reg` of lane `dbg_lane` one cycle after the address is presented.
- R11: `ld_valid` writes `ld_data` into register `ld_reg` of lane `ld_lane` whatever the enables are. It is ignored in a cycle with `op_valid`, and it is ignored for lanes 1 and up during a zero write (R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe for the lane-enable register |
| en_wdata | input | XLEN | Value written to the lane-enable register |
| en_q | output | XLEN | Current lane-enable register |
| part_mask | input | XLEN | Shared carry-break mask for packed adds |
| op_valid | input | 1 | Broadcast add strobe |
| op_packed | input | 1 | 1 = packed add, 0 = plain add |
| op_rd | input | log2(NREGS) | Destination register |
| op_rs1 | input | log2(NREGS) | First source register |
| op_rs2 | input | log2(NREGS) | Second source register |
| ld_valid | input | 1 | Single-lane load strobe |
| ld_lane | input | LANE_IW | Lane targeted by the load |
| ld_reg | input | log2(NREGS) | Register targeted by the load |
| ld_data | input | XLEN | Load data |
| dirty_clr | input | 1 | Clears all save-needed flags |
| dirty_q | output | NLANES | Save-needed flag per lane |
| dbg_lane | input | LANE_IW | Debug read lane |
| dbg_reg | input | log2(NREGS) | Debug read register |
| dbg_data | output | XLEN | Registered debug read data |

## Verification
The bench reads every register of every lane after each phase and compares it with a model that does packed sums element by element. A carry that leaks across a partition boundary, or a mask bit 0 that wrongly cuts the carry, therefore shows up as a wrong element value. It also targets several ordering faults:
- The enable write and the add arriving in the same cycle. A design that used the old enable would write the wrong lanes.
- A zero write padded with unimplemented bits. A design that tested the raw value would leave the enable at a non-implemented pattern and keep stale lane data.
- `dirty_clr` colliding with a load. A design that let the clear win would lose the save-needed flag.
- Adds and loads to register 0. A design that stored them would show nonzero reads or set a flag.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

  // Write source selected for one lane in one cycle
  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_ADD  = 2'd1,
    WR_LOAD = 2'd2
  } wr_src_e;

endpackage

// File: rtl/lrf_part_adder.sv
module lrf_part_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] mask_i,
  input  logic         packed_i,
  output logic [W-1:0] sum_o
);

  // Ripple chain; a mask bit kills the carry entering its position
  always_comb begin : ripple
    logic c;
    c = 1'b0;
    for (int i = 0; i < int'(W); i++) begin
      if (packed_i && mask_i[i]) c = 1'b0;
      sum_o[i] = a_i[i] ^ b_i[i] ^ c;
      c = (a_i[i] & b_i[i]) | (c & (a_i[i] ^ b_i[i]));
    end
  end

endmodule

// File: rtl/lrf_lane.sv
module lrf_lane
  import lrf_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned NREGS     = 32,
  parameter bit          CLEARABLE = 1'b1,
  localparam int unsigned RIW      = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            add_en_i,
  input  logic            ld_en_i,
  input  logic [RIW-1:0]  rd_i,
  input  logic [RIW-1:0]  rs1_i,
  input  logic [RIW-1:0]  rs2_i,
  input  logic [XLEN-1:0] part_mask_i,
  input  logic            packed_i,
  input  logic [RIW-1:0]  ld_reg_i,
  input  logic [XLEN-1:0] ld_data_i,
  input  logic [RIW-1:0]  dbg_reg_i,
  output logic [XLEN-1:0] dbg_data_o,
  output logic            wrote_o
);

  logic [XLEN-1:0] regs [NREGS];
  logic [XLEN-1:0] src1, src2, sum;
  wr_src_e         src;
  logic            clr_eff;

  assign clr_eff = clr_i && CLEARABLE;

  assign src1       = (rs1_i == '0) ? '0 : regs[rs1_i];
  assign src2       = (rs2_i == '0) ? '0 : regs[rs2_i];
  assign dbg_data_o = (dbg_reg_i == '0) ? '0 : regs[dbg_reg_i];

  lrf_part_adder #(.W(XLEN)) u_add (
    .a_i      (src1),
    .b_i      (src2),
    .mask_i   (part_mask_i),
    .packed_i (packed_i),
    .sum_o    (sum)
  );

  always_comb begin
    if (add_en_i)     src = WR_ADD;
    else if (ld_en_i) src = WR_LOAD;
    else              src = WR_NONE;
  end

  assign wrote_o = !clr_eff &&
                   (((src == WR_ADD) && (rd_i != '0)) ||
                    ((src == WR_LOAD) && (ld_reg_i != '0)));

  always_ff @(posedge clk) begin
    if (rst || clr_eff) begin
      for (int k = 0; k < int'(NREGS); k++) regs[k] <= '0;
    end else begin
      unique case (src)
        WR_ADD:  if (rd_i != '0) regs[rd_i] <= sum;
        WR_LOAD: if (ld_reg_i != '0) regs[ld_reg_i] <= ld_data_i;
        default: ;
      endcase
    end
  end

  // R5
  plain_sum_chk: assert property (@(posedge clk) disable iff (rst)
    !packed_i |-> sum == src1 + src2);

  // R3
  lane_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_eff |=> regs[NREGS-1] == '0 && regs[1] == '0);

endmodule

// File: rtl/lane_regfile.sv
module lane_regfile
  import lrf_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NLANES  = 4,
  parameter int unsigned NREGS   = 32,
  localparam int unsigned RIW    = $clog2(NREGS),
  localparam int unsigned LANE_IW = (NLANES > 1) ? $clog2(NLANES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_wr,
  input  logic [XLEN-1:0]    en_wdata,
  output logic [XLEN-1:0]    en_q,
  input  logic [XLEN-1:0]    part_mask,
  input  logic               op_valid,
  input  logic               op_packed,
  input  logic [RIW-1:0]     op_rd,
  input  logic [RIW-1:0]     op_rs1,
  input  logic [RIW-1:0]     op_rs2,
  input  logic               ld_valid,
  input  logic [LANE_IW-1:0] ld_lane,
  input  logic [RIW-1:0]     ld_reg,
  input  logic [XLEN-1:0]    ld_data,
  input  logic               dirty_clr,
  output logic [NLANES-1:0]  dirty_q,
  input  logic [LANE_IW-1:0] dbg_lane,
  input  logic [RIW-1:0]     dbg_reg,
  output logic [XLEN-1:0]    dbg_data
);

  localparam logic [XLEN-1:0]   IMPL_MASK  = {XLEN{1'b1}} >> (XLEN - NLANES);
  localparam logic [NLANES-1:0] SAVE_MASK  = {NLANES{1'b1}} << 1;

  logic [XLEN-1:0]   en_masked, en_next;
  logic              zero_wr;
  logic [NLANES-1:0] wrote;
  logic [NLANES-1:0] dirty_next;
  logic [XLEN-1:0]   lane_dbg [NLANES];

  // Enable register: new value is visible to a same-cycle add
  assign en_masked = en_wdata & IMPL_MASK;
  assign zero_wr   = en_wr && (en_masked == '0);

  always_comb begin
    if (!en_wr)       en_next = en_q;
    else if (zero_wr) en_next = XLEN'(1);
    else              en_next = en_masked;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= XLEN'(1);
    else     en_q <= en_next;
  end

  // Lanes
  for (genvar g = 0; g < int'(NLANES); g++) begin : g_lane
    lrf_lane #(
      .XLEN      (XLEN),
      .NREGS     (NREGS),
      .CLEARABLE (g != 0)
    ) u_lane (
      .clk         (clk),
      .rst         (rst),
      .clr_i       (zero_wr),
      .add_en_i    (op_valid && en_next[g]),
      .ld_en_i     (ld_valid && !op_valid && (int'(ld_lane) == g)),
      .rd_i        (op_rd),
      .rs1_i       (op_rs1),
      .rs2_i       (op_rs2),
      .part_mask_i (part_mask),
      .packed_i    (op_packed),
      .ld_reg_i    (ld_reg),
      .ld_data_i   (ld_data),
      .dbg_reg_i   (dbg_reg),
      .dbg_data_o  (lane_dbg[g]),
      .wrote_o     (wrote[g])
    );
  end

  // Save-needed flags: clear first, same-cycle writes set again
  always_comb begin
    if (zero_wr)        dirty_next = '0;
    else if (dirty_clr) dirty_next = wrote & SAVE_MASK;
    else                dirty_next = (dirty_q | wrote) & SAVE_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) dirty_q <= '0;
    else     dirty_q <= dirty_next;
  end

  // Registered debug read
  always_ff @(posedge clk) begin
    if (rst)                           dbg_data <= '0;
    else if (int'(dbg_lane) < NLANES)  dbg_data <= lane_dbg[dbg_lane];
    else                               dbg_data <= '0;
  end

  // R2
  en_impl_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q & ~IMPL_MASK) == '0);

  // R3
  en_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    en_q != '0);

  // R3
  zero_wr_en_chk: assert property (@(posedge clk) disable iff (rst)
    zero_wr |=> en_q == XLEN'(1) && dirty_q == '0);

  // R7
  dirty_lane0_chk: assert property (@(posedge clk) disable iff (rst)
    dirty_q[0] == 1'b0);

  // R8
  dirty_clr_chk: assert property (@(posedge clk) disable iff (rst)
    dirty_clr && !op_valid && !ld_valid |=> dirty_q == '0);

  // R4
  idle_en_chk: assert property (@(posedge clk) disable iff (rst)
    !en_wr |=> $stable(en_q));

endmodule

// File: tb/lane_regfile_tb.sv
module lane_regfile_tb;

  localparam int XL = 32;
  localparam int NL = 4;
  localparam int NR = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          en_wr;
  logic [31:0]   en_wdata;
  logic [31:0]   en_q;
  logic [31:0]   part_mask;
  logic          op_valid, op_packed;
  logic [4:0]    op_rd, op_rs1, op_rs2;
  logic          ld_valid;
  logic [1:0]    ld_lane;
  logic [4:0]    ld_reg;
  logic [31:0]   ld_data;
  logic          dirty_clr;
  logic [3:0]    dirty_q;
  logic [1:0]    dbg_lane;
  logic [4:0]    dbg_reg;
  logic [31:0]   dbg_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_regs [NL][NR];
  logic [31:0] m_en;
  logic [3:0]  m_dirty;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  lane_regfile #(.XLEN(XL), .NLANES(NL), .NREGS(NR)) u_dut (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata), .en_q(en_q),
    .part_mask(part_mask), .op_valid(op_valid), .op_packed(op_packed),
    .op_rd(op_rd), .op_rs1(op_rs1), .op_rs2(op_rs2), .ld_valid(ld_valid),
    .ld_lane(ld_lane), .ld_reg(ld_reg), .ld_data(ld_data),
    .dirty_clr(dirty_clr), .dirty_q(dirty_q), .dbg_lane(dbg_lane),
    .dbg_reg(dbg_reg), .dbg_data(dbg_data)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Element-wise reference: sums each partition segment separately
  function automatic logic [31:0] ref_add(logic [31:0] a, logic [31:0] b,
                                          logic [31:0] mask, logic pk);
    logic [63:0] m, s, res;
    int lo;
    if (!pk) return a + b;
    res = '0;
    lo  = 0;
    for (int i = 1; i <= 32; i++) begin
      if (i == 32 || mask[i]) begin
        m   = (64'd1 << (i - lo)) - 64'd1;
        s   = ((64'(a) >> lo) & m) + ((64'(b) >> lo) & m);
        res = res | ((s & m) << lo);
        lo  = i;
      end
    end
    return res[31:0];
  endfunction

  task automatic idle();
    en_wr = 0; en_wdata = '0; op_valid = 0; op_packed = 0;
    op_rd = '0; op_rs1 = '0; op_rs2 = '0; ld_valid = 0; ld_lane = '0;
    ld_reg = '0; ld_data = '0; dirty_clr = 0;
  endtask

  // Update the model from the driven inputs, then clock once
  task automatic tick();
    logic [31:0] nregs [NL][NR];
    logic [31:0] nen, em;
    logic [3:0]  ndirty;
    bit zw;
    nregs = m_regs; nen = m_en; ndirty = m_dirty; zw = 0;
    if (en_wr) begin
      em = en_wdata & 32'hF;
      if (em == 0) begin zw = 1; nen = 32'd1; end
      else nen = em;
    end
    if (dirty_clr || zw) ndirty = '0;
    if (zw) for (int l = 1; l < NL; l++) for (int r = 0; r < NR; r++) nregs[l][r] = '0;
    if (op_valid) begin
      for (int l = 0; l < NL; l++)
        if (nen[l] && op_rd != 0) begin
          nregs[l][op_rd] = ref_add(m_regs[l][op_rs1], m_regs[l][op_rs2], part_mask, op_packed);
          if (l != 0) ndirty[l] = 1'b1;
        end
    end else if (ld_valid && ld_reg != 0 && !(zw && ld_lane != 0)) begin
      nregs[ld_lane][ld_reg] = ld_data;
      if (ld_lane != 0) ndirty[ld_lane] = 1'b1;
    end
    m_regs = nregs; m_en = nen; m_dirty = ndirty;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic check_state(input string tag);
    chk(en_q, m_en, {tag, " en_q"});
    chk({28'd0, dirty_q}, {28'd0, m_dirty}, {tag, " dirty_q"});
  endtask

  // R10: registered debug read of every lane and register
  task automatic sweep(input string tag);
    for (int l = 0; l < NL; l++)
      for (int r = 0; r < NR; r++) begin
        dbg_lane = 2'(l); dbg_reg = 5'(r);
        @(posedge clk);
        @(negedge clk);
        chk(dbg_data, m_regs[l][r], $sformatf("%s R10 lane %0d reg %0d", tag, l, r));
      end
  endtask

  task automatic do_add(input int rd, input int rs1, input int rs2, input logic pk);
    op_valid = 1; op_packed = pk; op_rd = 5'(rd); op_rs1 = 5'(rs1); op_rs2 = 5'(rs2);
    tick();
  endtask

  task automatic do_en(input logic [31:0] v);
    en_wr = 1; en_wdata = v;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    part_mask = '0; dbg_lane = '0; dbg_reg = '0;
    rst = 1;
    for (int l = 0; l < NL; l++) for (int r = 0; r < NR; r++) m_regs[l][r] = '0;
    m_en = 32'd1; m_dirty = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state
    check_state("R1 reset");
    sweep("R1");

    // R2 high enable bits dropped
    do_en(32'hFFFF_FFFF);
    check_state("R2 enable mask");
    chk(en_q, 32'h0000_000F, "R2 en_q literal");

    // R11 seed every lane through the load port
    for (int l = 0; l < NL; l++)
      for (int r = 0; r < NR; r++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        ld_valid = 1; ld_lane = 2'(l); ld_reg = 5'(r); ld_data = seed;
        tick();
      end
    check_state("R7 R11 after loads");
    chk({28'd0, dirty_q}, 32'hE, "R7 lanes 1-3 flagged");
    sweep("R11 R6 loads");

    // R8 plain clear
    dirty_clr = 1; tick();
    check_state("R8 clear");

    // R4 R5 broadcast adds, plain and packed
    part_mask = 32'h0821_0820;
    for (int i = 1; i < 20; i++) begin
      do_add(i, (i * 7) % 32, (i * 13 + 3) % 32, i[0]);
      check_state("R4 R7 add");
    end
    part_mask = 32'hAAAA_5555;
    for (int i = 20; i < 32; i++) do_add(i, (i * 5) % 32, (i * 3 + 1) % 32, 1'b1);
    part_mask = 32'h0000_0001;
    do_add(2, 3, 4, 1'b1);
    do_add(6, 6, 6, 1'b0);
    check_state("R5 packed");
    sweep("R4 R5 all lanes");

    // R4 subset of lanes; R7 only enabled lane 2 flagged
    dirty_clr = 1; tick();
    do_en(32'h0000_0005);
    part_mask = 32'h8080_8080;
    for (int i = 8; i < 14; i++) do_add(i, i + 1, i + 2, 1'b1);
    check_state("R4 R7 subset");
    sweep("R4 subset");

    // R6 writes to register 0
    dirty_clr = 1; tick();
    do_en(32'h0000_000F);
    do_add(0, 5, 6, 1'b0);
    ld_valid = 1; ld_lane = 2'd3; ld_reg = 5'd0; ld_data = 32'hDEAD_BEEF; tick();
    check_state("R6 x0");
    chk({28'd0, dirty_q}, 32'h0, "R6 no flag");
    sweep("R6");

    // R8 clear collides with a load
    dirty_clr = 1; ld_valid = 1; ld_lane = 2'd2; ld_reg = 5'd3; ld_data = 32'h0BAD_F00D; tick();
    chk({28'd0, dirty_q}, 32'h4, "R8 same-cycle set wins");
    check_state("R8 collide");

    // R11 load ignored alongside add
    op_valid = 1; op_rd = 5'd9; op_rs1 = 5'd1; op_rs2 = 5'd2;
    ld_valid = 1; ld_lane = 2'd1; ld_reg = 5'd10; ld_data = 32'h1111_2222; tick();

    // R9 enable write and add in one cycle
    en_wr = 1; en_wdata = 32'h0000_0002;
    op_valid = 1; op_rd = 5'd7; op_rs1 = 5'd1; op_rs2 = 5'd2; tick();
    check_state("R9 same cycle");
    sweep("R9 R11");

    // R3 zero write padded with unimplemented bits, add in same cycle
    en_wr = 1; en_wdata = 32'hFFFF_FFF0;
    op_valid = 1; op_rd = 5'd5; op_rs1 = 5'd3; op_rs2 = 5'd4; tick();
    chk(en_q, 32'd1, "R3 en back to 1");
    chk({28'd0, dirty_q}, 32'h0, "R3 flags cleared");
    check_state("R3 R9");
    sweep("R3 lanes cleared");

    // R3 plain zero write with a load to lane 1 in same cycle
    do_en(32'h0000_000F);
    do_add(12, 13, 14, 1'b0);
    en_wr = 1; en_wdata = 32'h0;
    ld_valid = 1; ld_lane = 2'd1; ld_reg = 5'd4; ld_data = 32'h5555_AAAA; tick();
    check_state("R3 R11 zero write");
    sweep("R3 second");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule